// File: doc/BRIEF.md
# Write-Enable and Block-Protect Command Gate

This block sits behind the serial front-end of a serial non-volatile memory and decides whether a command that changes memory contents or configuration may proceed. When the front-end signals the end of a frame, the gate receives the captured opcode, the number of serial clock rising edges seen in the frame, the 17-bit target address and the first data byte. It checks that the frame ended on a byte boundary with a length that suits the opcode. It checks the write-enable latch. For writes, it compares the address against the protected region set by two protect bits. It then issues a one-cycle accept or reject pulse, plus a start pulse for the array programmer when a write is allowed.

The gate owns the write-enable latch, the two protect bits and a lock-enable bit. When the lock-enable bit is set and the external write-protect pin is driven low, the protect bits and the lock-enable bit cannot be changed. The array, page buffer and programming timer are outside the block. A single busy input stands for them. While busy is high, every command other than a status read is ignored, and busy appears as the progress bit of the status byte.

Opcodes are 06h set latch, 04h clear latch, 05h read status, 01h write status, 03h read and 02h write. A write frame carries three address bytes, of which the low 17 bits are used.

Top module: `wp_cmd_gate`

## Requirements
- R1: While reset is applied and after it is released, the latch, the protect bits and the lock-enable bit are 0, and no accept, reject or start pulse is present.
- R2: A frame must be byte aligned (bit count a multiple of eight). The set-latch and clear-latch frames must be exactly 8 bits, a write-status frame at least 16 bits and a write frame at least 40 bits. A frame that breaks these rules is rejected and changes no state.
- R3: A valid set-latch frame (06h) sets the latch (status bit 1) and a valid clear-latch frame (04h) clears it. Both are accepted.
- R4: A write-status (01h) or write (02h) frame that arrives with the latch clear is rejected and changes no state.
- R5: Protect bits 00 protect no address. 01 protects 18000h-1FFFFh, 10 protects 10000h-1FFFFh and 11 protects all addresses. A write whose start address is protected is rejected and gives no start pulse.
- R6: A valid write to an unprotected address with the latch set is accepted, pulses write_go, and clears the latch. A write rejected for protection also clears the latch.
- R7: An accepted write-status frame loads protect bits from data bits 3:2 and the lock-enable bit from data bit 7, and clears the latch.
- R8: With lock-enable set and wp_n low, a write-status frame is rejected, the protect bits and lock-enable are unchanged, and the latch is cleared.
- R9: While busy is high in the deselect cycle, every opcode other than 05h is ignored (no pulse, no state change). Status bit 0 follows busy.
- R10: The status byte is {lock-enable, 000, protect[1:0], latch, busy}. Read (03h), read-status (05h) and unknown opcodes give no pulse and change no state.
- R11: Result pulses appear in the cycle after cs_rise and last exactly one cycle. No pulse appears without a preceding cs_rise.
- R12: For the four opcodes 06h, 04h, 01h and 02h, when not ignored, exactly one of cmd_accept and cmd_reject pulses. write_go only pulses together with cmd_accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_rise | input | 1 | One-cycle pulse: chip select went inactive, frame complete |
| opcode | input | 8 | Opcode of the completed frame |
| bit_count | input | 12 | Serial clock rising edges seen in the frame |
| addr | input | 17 | Start address of a write frame |
| wr_byte | input | 8 | First data byte of the frame |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Array programming in progress |
| cmd_accept | output | 1 | Command accepted pulse |
| cmd_reject | output | 1 | Command rejected pulse |
| write_go | output | 1 | Start array write pulse |
| status | output | 8 | Status byte for read-back |

## Verification
The end of a frame and a change of the busy input can fall in the same clock cycle. The gate then has to judge the command by the busy value in that exact cycle. The bench holds busy high for several cycles and drops it in the very cycle that carries cs_rise, and expects the command to be processed. It then raises busy in the cs_rise cycle of another command and expects no pulse, with an unchanged latch seen through the status byte. A second overlap is a write-status frame that tries to clear the lock-enable bit while the lock is active. Its own data must not release the lock in the same decision; the status byte read afterwards shows whether it did.

// File: rtl/wp_cmd_gate_pkg.sv
package wp_cmd_gate_pkg;

  localparam logic [7:0] OP_SET_WEL = 8'h06;
  localparam logic [7:0] OP_CLR_WEL = 8'h04;
  localparam logic [7:0] OP_RD_STAT = 8'h05;
  localparam logic [7:0] OP_WR_STAT = 8'h01;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_WRITE   = 8'h02;

  typedef struct packed {
    logic       lock_en;
    logic [1:0] prot;
    logic       wel;
  } gate_state_t;

  typedef struct packed {
    logic acc;
    logic rej;
    logic go;
  } gate_result_t;

endpackage

// File: rtl/wp_cmd_frame.sv
module wp_cmd_frame
  import wp_cmd_gate_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int ADDR_BYTES = 3
) (
  input  logic [7:0]       opcode,
  input  logic [CNT_W-1:0] bit_count,
  output logic             frame_ok
);

  localparam int CTRL_BITS  = 8;
  localparam int STAT_MIN   = 16;
  localparam int WRITE_MIN  = 8 + ADDR_BYTES * 8 + 8;

  logic aligned;

  assign aligned = (bit_count[2:0] == 3'b000);

  always_comb begin
    frame_ok = 1'b0;
    case (opcode)
      OP_SET_WEL,
      OP_CLR_WEL: frame_ok = (bit_count == CNT_W'(CTRL_BITS));
      OP_WR_STAT: frame_ok = aligned && (bit_count >= CNT_W'(STAT_MIN));
      OP_WRITE:   frame_ok = aligned && (bit_count >= CNT_W'(WRITE_MIN));
      default:    frame_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/wp_cmd_region.sv
module wp_cmd_region #(
  parameter int ADDR_W = 17
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        prot,
  output logic              in_prot
);

  localparam int TOP = ADDR_W - 1;

  logic upper_quarter;
  logic upper_half;

  assign upper_quarter = addr[TOP] & addr[TOP-1];
  assign upper_half    = addr[TOP];

  always_comb begin
    case (prot)
      2'b00:   in_prot = 1'b0;
      2'b01:   in_prot = upper_quarter;
      2'b10:   in_prot = upper_half;
      default: in_prot = 1'b1;
    endcase
  end

endmodule

// File: rtl/wp_cmd_decide.sv
module wp_cmd_decide
  import wp_cmd_gate_pkg::*;
(
  input  logic         cs_rise,
  input  logic [7:0]   opcode,
  input  logic [7:0]   wr_byte,
  input  logic         wp_n,
  input  logic         busy,
  input  logic         frame_ok,
  input  logic         in_prot,
  input  gate_state_t  cur,
  output gate_state_t  nxt,
  output gate_result_t res
);

  logic locked;

  assign locked = cur.lock_en & ~wp_n;

  always_comb begin
    nxt = cur;
    res = '0;
    if (cs_rise && !busy) begin
      case (opcode)
        OP_SET_WEL: begin
          if (frame_ok) begin
            nxt.wel = 1'b1;
            res.acc = 1'b1;
          end else begin
            res.rej = 1'b1;
          end
        end
        OP_CLR_WEL: begin
          if (frame_ok) begin
            nxt.wel = 1'b0;
            res.acc = 1'b1;
          end else begin
            res.rej = 1'b1;
          end
        end
        OP_WR_STAT: begin
          if (!frame_ok || !cur.wel) begin
            res.rej = 1'b1;
          end else if (locked) begin
            nxt.wel = 1'b0;
            res.rej = 1'b1;
          end else begin
            nxt.wel     = 1'b0;
            nxt.prot    = wr_byte[3:2];
            nxt.lock_en = wr_byte[7];
            res.acc     = 1'b1;
          end
        end
        OP_WRITE: begin
          if (!frame_ok || !cur.wel) begin
            res.rej = 1'b1;
          end else if (in_prot) begin
            nxt.wel = 1'b0;
            res.rej = 1'b1;
          end else begin
            nxt.wel = 1'b0;
            res.acc = 1'b1;
            res.go  = 1'b1;
          end
        end
        default: begin
          nxt = cur;
        end
      endcase
    end
  end

endmodule

// File: rtl/wp_cmd_gate.sv
module wp_cmd_gate
  import wp_cmd_gate_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int ADDR_W     = 17,
  parameter int ADDR_BYTES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_rise,
  input  logic [7:0]        opcode,
  input  logic [CNT_W-1:0]  bit_count,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_byte,
  input  logic              wp_n,
  input  logic              busy,
  output logic              cmd_accept,
  output logic              cmd_reject,
  output logic              write_go,
  output logic [7:0]        status
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q_n;
  logic                   frame_ok;
  logic                   in_prot;
  logic                   state_en;
  gate_state_t            state_q;
  gate_state_t            state_d;
  gate_result_t           res_q;
  gate_result_t           res_d;

  // reset: asserted at once, released after SYNC_STAGES clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = rst_pipe[SYNC_STAGES-1];

  wp_cmd_frame #(
    .CNT_W      (CNT_W),
    .ADDR_BYTES (ADDR_BYTES)
  ) u_frame (
    .opcode    (opcode),
    .bit_count (bit_count),
    .frame_ok  (frame_ok)
  );

  wp_cmd_region #(
    .ADDR_W (ADDR_W)
  ) u_region (
    .addr    (addr),
    .prot    (state_q.prot),
    .in_prot (in_prot)
  );

  wp_cmd_decide u_decide (
    .cs_rise  (cs_rise),
    .opcode   (opcode),
    .wr_byte  (wr_byte),
    .wp_n     (wp_n),
    .busy     (busy),
    .frame_ok (frame_ok),
    .in_prot  (in_prot),
    .cur      (state_q),
    .nxt      (state_d),
    .res      (res_d)
  );

  // state only moves on a frame end
  assign state_en = cs_rise;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= '0;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      res_q <= '0;
    end else begin
      res_q <= res_d;
    end
  end

  assign cmd_accept = res_q.acc;
  assign cmd_reject = res_q.rej;
  assign write_go   = res_q.go;
  assign status     = {state_q.lock_en, 3'b000, state_q.prot, state_q.wel, busy};

endmodule

// File: rtl/wp_cmd_gate_chk.sv
module wp_cmd_gate_chk
  import wp_cmd_gate_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_rise,
  input logic [7:0] opcode,
  input logic       wp_n,
  input logic       busy,
  input logic       cmd_accept,
  input logic       cmd_reject,
  input logic       write_go,
  input logic [7:0] status
);

  // R12: never both verdicts at once
  assert_one_verdict_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_accept, cmd_reject}));

  // R12: start pulse only with acceptance
  assert_go_with_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    write_go |-> cmd_accept);

  // R11: verdicts only follow a frame end
  assert_pulse_after_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept || cmd_reject) |-> $past(cs_rise));

  // R3: latch rises only after a set-latch frame
  assert_wel_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(cs_rise && opcode == OP_SET_WEL));

  // R6: a write start needs the latch one cycle earlier
  assert_go_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    write_go |-> $past(status[1]));

  // R9: busy frames other than status read are ignored
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_rise && busy && opcode != OP_RD_STAT) |-> !cmd_accept && !cmd_reject);

  // R8: locked configuration bits stay put
  assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_rise && status[7] && !wp_n) |-> $stable(status[7:2]));

  // R7: protect bits change only after a write-status frame
  assert_prot_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_rise && opcode == OP_WR_STAT) |-> $stable(status[3:2]));

endmodule

bind wp_cmd_gate wp_cmd_gate_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .cs_rise    (cs_rise),
  .opcode     (opcode),
  .wp_n       (wp_n),
  .busy       (busy),
  .cmd_accept (cmd_accept),
  .cmd_reject (cmd_reject),
  .write_go   (write_go),
  .status     (status)
);

// File: tb/wp_cmd_gate_bench.sv
module wp_cmd_gate_bench;

  logic        clk;
  logic        rst_n;
  logic        cs_rise;
  logic [7:0]  opcode;
  logic [11:0] bit_count;
  logic [16:0] addr;
  logic [7:0]  wr_byte;
  logic        wp_n;
  logic        busy;
  logic        cmd_accept;
  logic        cmd_reject;
  logic        write_go;
  logic [7:0]  status;

  int tests;
  int fails;
  bit done;

  wp_cmd_gate u_wp_cmd_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_rise    (cs_rise),
    .opcode     (opcode),
    .bit_count  (bit_count),
    .addr       (addr),
    .wr_byte    (wr_byte),
    .wp_n       (wp_n),
    .busy       (busy),
    .cmd_accept (cmd_accept),
    .cmd_reject (cmd_reject),
    .write_go   (write_go),
    .status     (status)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [7:0]  op;
    logic [11:0] cnt;
    logic [16:0] adr;
    logic [7:0]  dat;
    logic        wpn;
    logic        bsy;
    logic        acc;
    logic        rej;
    logic        go;
    logic [7:0]  st;
  } vec_t;

  localparam int NV = 36;
  // op, bits, addr, data, wp_n, busy, acc, rej, go, status
  localparam vec_t VEC [NV] = '{
    '{8'h06, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h02}, // R3
    '{8'h04, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R3
    '{8'h02, 12'd40, 17'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00}, // R4
    '{8'h06, 12'd7,  17'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00}, // R2
    '{8'h06, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h02},
    '{8'h01, 12'd16, 17'h00000, 8'h84, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h84}, // R7
    '{8'h06, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h86},
    '{8'h02, 12'd40, 17'h18000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h84}, // R5 R6
    '{8'h06, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h86},
    '{8'h02, 12'd48, 17'h17FFF, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h84}, // R6
    '{8'h06, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h86},
    '{8'h02, 12'd44, 17'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h86}, // R2
    '{8'h01, 12'd16, 17'h00000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h84}, // R8
    '{8'h06, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h86},
    '{8'h01, 12'd16, 17'h00000, 8'h08, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h08}, // R7
    '{8'h06, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h09}, // R9
    '{8'h05, 12'd16, 17'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h08}, // R10
    '{8'h06, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0A},
    '{8'h02, 12'd40, 17'h10000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h08}, // R5
    '{8'h06, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0A},
    '{8'h02, 12'd40, 17'h0FFFF, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h08}, // R5
    '{8'h06, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0A},
    '{8'h01, 12'd8,  17'h00000, 8'h0C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0A}, // R2
    '{8'h01, 12'd16, 17'h00000, 8'h0C, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0C}, // R7
    '{8'h06, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0E},
    '{8'h02, 12'd40, 17'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0C}, // R5
    '{8'h06, 12'd16, 17'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0C}, // R2
    '{8'h03, 12'd32, 17'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0C}, // R10
    '{8'h06, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0E},
    '{8'h01, 12'd16, 17'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
    '{8'h06, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h02},
    '{8'h02, 12'd40, 17'h1FFFF, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00}, // R5
    '{8'hAB, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R10
    '{8'h06, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h02},
    '{8'h04, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h03}, // R9
    '{8'h04, 12'd8,  17'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}  // R12
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive a frame end at a falling edge; verdict is sampled one cycle later
  task automatic issue(input logic [7:0] op, input logic [11:0] cnt, input logic [16:0] a,
                       input logic [7:0] d, input logic wpn, input logic bsy);
    @(negedge clk);
    opcode    = op;
    bit_count = cnt;
    addr      = a;
    wr_byte   = d;
    wp_n      = wpn;
    busy      = bsy;
    cs_rise   = 1'b1;
    @(negedge clk);
    cs_rise   = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tests = 0;
    fails = 0;
    done = 1'b0;
    rst_n = 1'b0;
    cs_rise = 1'b0;
    opcode = 8'h00;
    bit_count = '0;
    addr = '0;
    wr_byte = 8'h00;
    wp_n = 1'b1;
    busy = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 status in reset", {24'd0, status}, 32'h00);
    check("R1 pulses in reset", {29'd0, cmd_accept, cmd_reject, write_go}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 status after reset", {24'd0, status}, 32'h00);
    check("R1 pulses after reset", {29'd0, cmd_accept, cmd_reject, write_go}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].op, VEC[i].cnt, VEC[i].adr, VEC[i].dat, VEC[i].wpn, VEC[i].bsy);
      check($sformatf("R12 accept vec %0d", i), {31'd0, cmd_accept}, {31'd0, VEC[i].acc});
      check($sformatf("R12 reject vec %0d", i), {31'd0, cmd_reject}, {31'd0, VEC[i].rej});
      check($sformatf("R6 write_go vec %0d", i), {31'd0, write_go}, {31'd0, VEC[i].go});
      check($sformatf("R10 status vec %0d", i), {24'd0, status}, {24'd0, VEC[i].st});
    end
    busy = 1'b0;
    wp_n = 1'b1;

    // R11: pulse lasts one cycle
    issue(8'h06, 12'd8, '0, 8'h00, 1'b1, 1'b0);
    check("R11 pulse present", {31'd0, cmd_accept}, 32'd1);
    @(negedge clk);
    check("R11 pulse gone", {30'd0, cmd_accept, cmd_reject}, 32'd0);

    // R9: busy falls in the very cycle of the frame end -> processed
    busy = 1'b1;
    repeat (3) @(negedge clk);
    issue(8'h04, 12'd8, '0, 8'h00, 1'b1, 1'b0);
    check("R9 busy fell same cycle accepted", {31'd0, cmd_accept}, 32'd1);
    check("R9 busy fell same cycle status", {24'd0, status}, 32'h00);

    // R9: busy rises in the frame-end cycle -> ignored, latch untouched
    issue(8'h06, 12'd8, '0, 8'h00, 1'b1, 1'b1);
    check("R9 busy rose same cycle no pulse", {30'd0, cmd_accept, cmd_reject}, 32'd0);
    check("R9 busy rose status", {24'd0, status}, 32'h01);
    busy = 1'b0;

    // R8: lock inactive when pin high even with lock-enable set
    issue(8'h06, 12'd8, '0, 8'h00, 1'b1, 1'b0);
    issue(8'h01, 12'd16, '0, 8'h84, 1'b1, 1'b0);
    check("R7 set lock-enable", {24'd0, status}, 32'h84);
    issue(8'h06, 12'd8, '0, 8'h00, 1'b0, 1'b0);
    issue(8'h01, 12'd24, '0, 8'h0C, 1'b0, 1'b0);
    check("R8 locked reject", {31'd0, cmd_reject}, 32'd1);
    check("R8 locked status", {24'd0, status}, 32'h84);
    issue(8'h06, 12'd8, '0, 8'h00, 1'b1, 1'b0);
    issue(8'h01, 12'd24, '0, 8'h0C, 1'b1, 1'b0);
    check("R8 pin high unlocked", {24'd0, status}, 32'h0C);

    // R1: asynchronous reset in the middle of operation
    issue(8'h06, 12'd8, '0, 8'h00, 1'b1, 1'b0);
    check("R3 latch before reset", {24'd0, status}, 32'h0E);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset clears", {24'd0, status}, 32'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after mid-run reset", {24'd0, status}, 32'h00);

    finish_run();
  end

endmodule